// File: doc/BRIEF.md
# Cache test-port address sequencer

This block sits behind the data-side test command register of a level-one memory subsystem. When software writes a nonzero command, the block builds an indirect L1 memory address from a fixed scatter of command bits. It ORs that address with an SRAM base value and then moves 64 bits between its two 32-bit test data words and a memory port. A single command bit chooses whether the words go out to memory or come back from it.

The memory port uses a plain request/acknowledge handshake and carries two 32-bit beats, at the scattered address and at that address plus four. Commands that use undefined bits, or that ask for the tag array instead of the data array, start no transfer and raise a one-cycle error pulse. The companion instruction-side command register is not implemented. Writing a nonzero value to it raises its own error pulse.

Top module: `cache_test_seq`

## Requirements
- R1: A write of zero to the command register stores zero and starts no transfer; busy stays low and no error pulse is raised.
- R2: The transfer address is the SRAM base ORed with a scatter of the command word, with these mappings: command bit 26 to address bit 11, bit 24 to bit 21, bit 23 to bit 15, bits 17:16 to bits 13:12, bit 14 to bit 14, and bits 10:3 to bits 10:3. All other address bits come from the base alone. Beat 0 uses this address and beat 1 uses it plus 4.
- R3: A nonzero command with any bit set under mask 0xFA7CB801 gives a one-cycle err_undef pulse in the cycle after the write. It starts no transfer, and the command is still stored.
- R4: A nonzero command with bit 2 (data-array select) clear gives a one-cycle err_tag pulse in the cycle after the write and starts no transfer.
- R5: With bit 1 set (write), mem_we is high and beat 0 carries test data word 0 while beat 1 carries word 1.
- R6: With bit 1 clear (read), mem_we is low and the read data acknowledged on beat 0 and beat 1 land in test data words 0 and 1.
- R7: busy rises in the cycle after a command is accepted and falls in the cycle after the second beat is acknowledged. While mem_req waits for mem_ack, mem_addr and mem_we hold steady.
- R8: A command written while busy is ignored: it is not stored, it starts no transfer and it raises no error.
- R9: Host writes to the test data words while busy are ignored.
- R10: A nonzero write to the instruction-side command register gives a one-cycle err_inst pulse; a zero write gives none.
- R11: After reset, the command register, both test data words, busy, mem_req and all error outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sram_base | input | 32 | Base address ORed into the scattered address |
| cmd_wr_en | input | 1 | Write strobe for the data-side command register |
| cmd_wr_data | input | 32 | Command word |
| dat_wr_en | input | 2 | Write strobes for test data words 1 and 0 |
| dat_wr_data | input | 32 | Host value for a test data word |
| icmd_wr_en | input | 1 | Write strobe for the instruction-side command register |
| icmd_wr_data | input | 32 | Instruction-side command word |
| mem_ack | input | 1 | Memory accepts or returns the current beat |
| mem_rdata | input | 32 | Read data for the acknowledged beat |
| cmd_q | output | 32 | Stored command value |
| dat0_q | output | 32 | Test data word 0 |
| dat1_q | output | 32 | Test data word 1 |
| busy | output | 1 | Transfer in progress |
| err_undef | output | 1 | Undefined-bit error pulse |
| err_tag | output | 1 | Tag-array request error pulse |
| err_inst | output | 1 | Instruction-side command error pulse |
| mem_req | output | 1 | Beat request |
| mem_we | output | 1 | Beat direction, high for write |
| mem_addr | output | 32 | Beat address |
| mem_wdata | output | 32 | Beat write data |

## Verification
The in-design assertions check, on every cycle, the properties that hold whatever the command: mem_addr and mem_we stay steady under a pending request, busy drops after the final beat, rejected and faulty commands never raise a request, and the stored command and data words stay frozen while busy. Whether the scatter sends each command bit to the right address bit, whether read data reaches the right word, and whether the error pulses come from the right bits can only be shown by the bench's scenarios. Its scoreboard predicts every beat from its own bit mapping and holds a memory image to compare readbacks.

// File: rtl/ctp_pkg.sv
`timescale 1ns/1ps
package ctp_pkg;
  localparam int          CMD_W        = 32;
  localparam int          NWORDS       = 2;
  localparam logic [31:0] UNDEF_MASK   = 32'hFA7CB801;
  localparam int          DATA_SEL_BIT = 2;
  localparam int          WRITE_BIT    = 1;

  // Scatter of command bits onto L1 address positions.
  function automatic logic [31:0] scatter_cmd(input logic [31:0] c);
    logic [31:0] a;
    a        = '0;
    a[11]    = c[26];
    a[21]    = c[24];
    a[15]    = c[23];
    a[13:12] = c[17:16];
    a[14]    = c[14];
    a[10:3]  = c[10:3];
    return a;
  endfunction

  function automatic logic [31:0] build_addr(input logic [31:0] c, input logic [31:0] base);
    return base | scatter_cmd(c);
  endfunction
endpackage

// File: rtl/ctp_cmd_decode.sv
`timescale 1ns/1ps
module ctp_cmd_decode
  import ctp_pkg::*;
(
  input  logic        cmd_wr_en,
  input  logic [31:0] cmd_data,
  input  logic        busy,
  input  logic [31:0] sram_base,
  output logic        accept,
  output logic        bad_undef,
  output logic        bad_tag,
  output logic        start,
  output logic [31:0] start_addr,
  output logic        start_we
);
  logic nonzero;

  always_comb begin
    accept     = cmd_wr_en & ~busy;
    nonzero    = |cmd_data;
    bad_undef  = accept & nonzero & (|(cmd_data & UNDEF_MASK));
    bad_tag    = accept & nonzero & ~cmd_data[DATA_SEL_BIT];
    start      = accept & nonzero & ~bad_undef & ~bad_tag;
    start_addr = build_addr(cmd_data, sram_base);
    start_we   = cmd_data[WRITE_BIT];
  end
endmodule

// File: rtl/ctp_xfer_ctrl.sv
`timescale 1ns/1ps
module ctp_xfer_ctrl #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          start_we,
  input  logic          mem_ack,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [(NB>1 ? $clog2(NB) : 1)-1:0] beat_idx,
  output logic          beat_ack
);
  localparam int BW      = (NB > 1) ? $clog2(NB) : 1;
  localparam int STEP_SH = $clog2(DW / 8);
  localparam logic [BW-1:0] LAST = BW'(NB - 1);

  logic          active;
  logic [BW-1:0] beat;
  logic [AW-1:0] base_q;
  logic          we_q;
  logic          last_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
      base_q <= '0;
      we_q   <= 1'b0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        beat   <= '0;
        base_q <= start_addr;
        we_q   <= start_we;
      end
    end else if (mem_ack) begin
      if (beat == LAST) active <= 1'b0;
      else              beat   <= beat + 1'b1;
    end
  end

  assign last_beat = (beat == LAST);
  assign busy      = active;
  assign mem_req   = active;
  assign mem_we    = we_q;
  assign mem_addr  = base_q + (AW'(beat) << STEP_SH);
  assign beat_idx  = beat;
  assign beat_ack  = active & mem_ack;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ack && last_beat) |=> !busy); // R7
endmodule

// File: rtl/ctp_data_regs.sv
`timescale 1ns/1ps
module ctp_data_regs #(
  parameter int DW = 32,
  parameter int NW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NW-1:0]       host_we,
  input  logic [DW-1:0]       host_data,
  input  logic                busy,
  input  logic                xfer_we,
  input  logic                beat_ack,
  input  logic [(NW>1 ? $clog2(NW) : 1)-1:0] beat_idx,
  input  logic [DW-1:0]       rdata,
  output logic [NW-1:0][DW-1:0] words
);
  localparam int BW = (NW > 1) ? $clog2(NW) : 1;

  for (genvar i = 0; i < NW; i++) begin : g_word
    logic load_host, load_mem;
    assign load_host = host_we[i] & ~busy;
    assign load_mem  = beat_ack & ~xfer_we & (beat_idx == BW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         words[i] <= '0;
      else if (load_mem)  words[i] <= rdata;
      else if (load_host) words[i] <= host_data;
    end

    AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && xfer_we) |=> $stable(words[i])); // R9
  end
endmodule

// File: rtl/cache_test_seq.sv
`timescale 1ns/1ps
module cache_test_seq
  import ctp_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] sram_base,
  input  logic          cmd_wr_en,
  input  logic [31:0]   cmd_wr_data,
  input  logic [1:0]    dat_wr_en,
  input  logic [DW-1:0] dat_wr_data,
  input  logic          icmd_wr_en,
  input  logic [31:0]   icmd_wr_data,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic [31:0]   cmd_q,
  output logic [DW-1:0] dat0_q,
  output logic [DW-1:0] dat1_q,
  output logic          busy,
  output logic          err_undef,
  output logic          err_tag,
  output logic          err_inst,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  localparam int BW = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic          accept, bad_undef, bad_tag, start, start_we;
  logic [31:0]   start_addr;
  logic [BW-1:0] beat_idx;
  logic          beat_ack;
  logic [NWORDS-1:0][DW-1:0] words;

  ctp_cmd_decode u_dec (
    .cmd_wr_en (cmd_wr_en),
    .cmd_data  (cmd_wr_data),
    .busy      (busy),
    .sram_base (sram_base),
    .accept    (accept),
    .bad_undef (bad_undef),
    .bad_tag   (bad_tag),
    .start     (start),
    .start_addr(start_addr),
    .start_we  (start_we)
  );

  ctp_xfer_ctrl #(.AW(AW), .DW(DW), .NB(NWORDS)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_addr(start_addr),
    .start_we  (start_we),
    .mem_ack   (mem_ack),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .beat_idx  (beat_idx),
    .beat_ack  (beat_ack)
  );

  ctp_data_regs #(.DW(DW), .NW(NWORDS)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_we  (dat_wr_en),
    .host_data(dat_wr_data),
    .busy     (busy),
    .xfer_we  (mem_we),
    .beat_ack (beat_ack),
    .beat_idx (beat_idx),
    .rdata    (mem_rdata),
    .words    (words)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      err_undef <= 1'b0;
      err_tag   <= 1'b0;
      err_inst  <= 1'b0;
    end else begin
      if (accept) cmd_q <= cmd_wr_data;
      err_undef <= bad_undef;
      err_tag   <= bad_tag;
      err_inst  <= icmd_wr_en & (|icmd_wr_data);
    end
  end

  assign dat0_q    = words[0];
  assign dat1_q    = words[1];
  assign mem_wdata = words[beat_idx];

  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_en && !busy && cmd_wr_data == 32'h0) |=> !busy); // R1
  AST_UNDEF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err_undef |-> !mem_req); // R3
  AST_TAG_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err_tag |-> !mem_req); // R4
  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr_en) |=> ($stable(cmd_q) && !err_undef && !err_tag)); // R8
  AST_INST_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (icmd_wr_en && icmd_wr_data != 32'h0) |=> err_inst); // R10
endmodule

// File: tb/cache_test_seq_tb.sv
`timescale 1ns/1ps
module cache_test_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] sram_base = 32'hFF800000;
  logic        cmd_wr_en = 1'b0;
  logic [31:0] cmd_wr_data = '0;
  logic [1:0]  dat_wr_en = '0;
  logic [31:0] dat_wr_data = '0;
  logic        icmd_wr_en = 1'b0;
  logic [31:0] icmd_wr_data = '0;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] cmd_q, dat0_q, dat1_q, mem_addr, mem_wdata;
  logic        busy, err_undef, err_tag, err_inst, mem_req, mem_we;

  always #2.5 clk = ~clk;

  cache_test_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sram_base(sram_base),
    .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
    .dat_wr_en(dat_wr_en), .dat_wr_data(dat_wr_data),
    .icmd_wr_en(icmd_wr_en), .icmd_wr_data(icmd_wr_data),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cmd_q(cmd_q), .dat0_q(dat0_q), .dat1_q(dat1_q), .busy(busy),
    .err_undef(err_undef), .err_tag(err_tag), .err_inst(err_inst),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Bench's own statement of the bit scatter (R2).
  function automatic logic [31:0] ref_addr(input logic [31:0] c, input logic [31:0] base);
    int src [14] = '{3, 4, 5, 6, 7, 8, 9, 10, 14, 16, 17, 23, 24, 26};
    int dst [14] = '{3, 4, 5, 6, 7, 8, 9, 10, 14, 12, 13, 15, 21, 11};
    logic [31:0] a = base;
    for (int k = 0; k < 14; k++) if (c[src[k]]) a[dst[k]] = 1'b1;
    return a;
  endfunction

  typedef struct { logic [31:0] addr; logic we; logic [31:0] wdata; } beat_t;
  beat_t       exp_q[$];
  logic [31:0] mem_img [logic [31:0]];
  int          stall = 0;
  int          beat_no = 0;

  task automatic push_xfer(input logic [31:0] c, input logic [31:0] base,
                           input logic [31:0] d0, input logic [31:0] d1);
    logic [31:0] a = ref_addr(c, base);
    exp_q.push_back('{addr: a,      we: c[1], wdata: d0});
    exp_q.push_back('{addr: a + 4,  we: c[1], wdata: d1});
  endtask

  // Monitor and memory responder.
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req && rst_n) begin
      if (stall > 0) stall--;
      else begin
        beat_t e;
        if (exp_q.size() == 0) begin
          chk("R8", "unexpected beat addr", mem_addr, 32'hFFFFFFFF);
        end else begin
          e = exp_q.pop_front();
          chk("R2", "beat address", mem_addr, e.addr);
          chk(e.we ? "R5" : "R6", "beat direction", 32'(mem_we), 32'(e.we));
          if (e.we) chk("R5", "beat write data", mem_wdata, e.wdata);
        end
        if (mem_we) mem_img[mem_addr] = mem_wdata;
        mem_rdata = mem_img.exists(mem_addr) ? mem_img[mem_addr] : (32'hDEAD0000 ^ mem_addr);
        mem_ack = 1'b1;
        beat_no++;
        stall = beat_no % 3;
      end
    end
  end

  task automatic do_cmd(input logic [31:0] c);
    @(negedge clk); cmd_wr_en = 1'b1; cmd_wr_data = c;
    @(negedge clk); cmd_wr_en = 1'b0;
  endtask

  task automatic do_dat(input int idx, input logic [31:0] v);
    @(negedge clk); dat_wr_en = 2'b01 << idx; dat_wr_data = v;
    @(negedge clk); dat_wr_en = 2'b00;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 200 && busy; n++) @(negedge clk);
    chk("R7", "busy falls after transfer", 32'(busy), 32'h0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] c1, c2, c3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "cmd_q", cmd_q, 32'h0);
    chk("R11", "dat0", dat0_q, 32'h0);
    chk("R11", "dat1", dat1_q, 32'h0);
    chk("R11", "busy/req", {30'h0, busy, mem_req}, 32'h0);
    chk("R11", "errors", {29'h0, err_undef, err_tag, err_inst}, 32'h0);

    // Write transfer (R5, R2, R7, R8, R9)
    do_dat(0, 32'h11112222);
    do_dat(1, 32'h33334444);
    c1 = (32'h1 << 26) | (32'h1 << 23) | (32'h1 << 16) | (32'h1 << 14) | 32'h0A8 | 32'h6;
    push_xfer(c1, sram_base, 32'h11112222, 32'h33334444);
    do_cmd(c1);
    chk("R7", "busy after accept", 32'(busy), 32'h1);
    chk("R1", "cmd stored", cmd_q, c1);
    do_dat(0, 32'hBADBAD00);                  // R9: ignored while busy
    do_cmd(32'h00000106);                     // R8: ignored while busy
    chk("R8", "no error for rejected cmd", {30'h0, err_undef, err_tag}, 32'h0);
    wait_idle();
    chk("R9", "dat0 kept", dat0_q, 32'h11112222);
    chk("R8", "cmd_q kept", cmd_q, c1);

    // Read transfer back (R6)
    do_dat(0, 32'h0);
    do_dat(1, 32'h0);
    c2 = c1 & ~32'h2;
    push_xfer(c2, sram_base, 32'h0, 32'h0);
    do_cmd(c2);
    wait_idle();
    chk("R6", "read word0", dat0_q, 32'h11112222);
    chk("R6", "read word1", dat1_q, 32'h33334444);

    // Other scatter bits and another base (R2)
    sram_base = 32'h00400000;
    do_dat(0, 32'h5555AAAA);
    do_dat(1, 32'h0F0F0F0F);
    c3 = (32'h1 << 24) | (32'h1 << 17) | 32'h610 | 32'h6;
    push_xfer(c3, sram_base, 32'h5555AAAA, 32'h0F0F0F0F);
    do_cmd(c3);
    wait_idle();
    do_dat(0, 32'h0);
    do_dat(1, 32'h0);
    push_xfer(c3 & ~32'h2, sram_base, 32'h0, 32'h0);
    do_cmd(c3 & ~32'h2);
    wait_idle();
    chk("R6", "readback word0", dat0_q, 32'h5555AAAA);
    chk("R6", "readback word1", dat1_q, 32'h0F0F0F0F);

    // Undefined bits (R3)
    do_cmd(32'h80000006);
    chk("R3", "err_undef pulse", 32'(err_undef), 32'h1);
    chk("R3", "no transfer", {30'h0, busy, mem_req}, 32'h0);
    chk("R3", "cmd stored", cmd_q, 32'h80000006);
    @(negedge clk);
    chk("R3", "pulse one cycle", 32'(err_undef), 32'h0);
    do_cmd(32'h00000007);
    chk("R3", "bit0 undefined", 32'(err_undef), 32'h1);
    chk("R3", "bit0 no transfer", 32'(busy), 32'h0);

    // Tag array request (R4)
    do_cmd(32'h00000402);
    chk("R4", "err_tag pulse", 32'(err_tag), 32'h1);
    chk("R4", "no undef", 32'(err_undef), 32'h0);
    chk("R4", "no transfer", {30'h0, busy, mem_req}, 32'h0);

    // Zero command (R1)
    do_cmd(32'h0);
    chk("R1", "zero stored", cmd_q, 32'h0);
    chk("R1", "no transfer", {30'h0, busy, mem_req}, 32'h0);
    chk("R1", "no error", {30'h0, err_undef, err_tag}, 32'h0);

    // Instruction-side register (R10)
    @(negedge clk); icmd_wr_en = 1'b1; icmd_wr_data = 32'h5;
    @(negedge clk); icmd_wr_en = 1'b0;
    chk("R10", "err_inst on nonzero", 32'(err_inst), 32'h1);
    @(negedge clk); icmd_wr_en = 1'b1; icmd_wr_data = 32'h0;
    @(negedge clk); icmd_wr_en = 1'b0;
    chk("R10", "no err_inst on zero", 32'(err_inst), 32'h0);

    repeat (4) @(negedge clk);
    chk("R2", "scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule